// File: doc/BRIEF.md
# Stereo Audio Transmit FIFO with Free-Space Interrupts

This block sits between a CPU register port and a serial audio output. It queues stereo samples in a small FIFO. Each entry pairs a left sample with a right sample. Software can load an entry in two ways. A single wide write supplies both samples at once. Two narrow writes supply the left sample first and then the right sample.

The output side asks for one stereo entry at a time with a pop request. The output side is the serial shifter, which is not part of this block. A run control governs consumption. After run is raised, nothing leaves the FIFO until software has filled all of it once. Until then the output receives silence.

Three sticky free-space flags report when one entry, half the entries or all the entries have become free. Each flag has its own enable. The enabled flags are ORed onto a single interrupt line. A sticky underrun bit records any pop that found an armed FIFO empty.

Top module: `audio_tx_fifo_irq`

## Requirements
- R1: After reset `level` is 0, `flags`, `underrun`, `irq` and `out_valid` are 0, and both output samples are 0.
- R2: A wide write (`wr_word`) stores one entry in one cycle: bits [15:0] become the left sample and bits [31:16] the right sample. `level` rises by one on the following edge.
- R3: Narrow writes (`wr_half`, data on bits [15:0]) pair up. The first is held as the left sample and does not change `level`. The second supplies the right sample and commits the entry.
- R4: A wide write discards a held left sample. The next narrow write starts a new pair as a left sample.
- R5: A write that arrives while `level` equals the depth (4) is dropped. `level` stays 4 and the stored order is unchanged.
- R6: While `run_en` is high but the FIFO has not yet reached full since `run_en` rose, a pop returns zero samples. It leaves `level` unchanged and does not set `underrun`. Lowering `run_en` re-arms this rule.
- R7: Popped entries leave in write order. `out_valid` pulses on the edge after each accepted pop request, carrying that entry.
- R8: Flag bit 0 (one free) sets on the edge where the free count rises to 1.
- R9: Flag bit 1 (half free) sets on the edge where the free count rises to 2.
- R10: Flag bit 2 (all free) sets on the edge where the last entry is popped.
- R11: Flags are sticky and clear only when the matching `status_clr` bit [2:0] is pulsed high. A set in the same cycle takes priority over the clear.
- R12: `irq` is high exactly when some flag bit and its `irq_en` bit are both 1. With `irq_en` at 0, no flag raises `irq`.
- R13: A pop once the FIFO is armed and empty returns zero samples and sets `underrun`. `underrun` stays high until `status_clr[3]` is pulsed.
- R14: A pop request with `run_en` low is ignored: no `out_valid`, and `level` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run control; gates consumption and arms the fill-first rule |
| wr_half | input | 1 | Narrow write strobe, sample on `wr_data[15:0]` |
| wr_word | input | 1 | Wide write strobe, left on [15:0], right on [31:16]; wins over `wr_half` |
| wr_data | input | 32 | Write data |
| irq_en | input | 3 | Per-flag interrupt enables (bit 0 one free, bit 1 half free, bit 2 all free) |
| status_clr | input | 4 | Write-1-to-clear pulses: [2:0] flags, [3] underrun |
| pop_req | input | 1 | Request for the next stereo entry |
| out_valid | output | 1 | One-cycle pulse after an accepted pop request |
| out_left | output | 16 | Left sample, zero on underrun or before arming |
| out_right | output | 16 | Right sample, zero on underrun or before arming |
| level | output | 3 | Stored entries, 0 to 4 |
| flags | output | 3 | Sticky free-space flags |
| underrun | output | 1 | Sticky underrun status |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions assume three things about the inputs. First, `level` can only drop through a pop. Second, at most one pop request arrives per cycle. Third, `rst_n` is held for at least one edge before any traffic starts. Under these assumptions the free count moves by at most one per edge, and each flag rise can be tied to a single level value. The stimulus issues writes and pops in separate cycles. It never pulses a clear in the same cycle as a pop, so every flag change can be traced to one event. The stimulus also drops `run_en` and later raises it again, which exercises the re-arming path.

// File: rtl/atf_pkg.sv
package atf_pkg;

   // Flag bit positions, shared by the flag bank and the clear port.
   localparam int FLAG_ONE  = 0;
   localparam int FLAG_HALF = 1;
   localparam int FLAG_ALL  = 2;
   localparam int NFLAGS    = 3;
   localparam int CLR_UNDER = 3;

   // Free-space threshold belonging to each flag bit.
   function automatic int flag_threshold(input int idx, input int depth);
      case (idx)
         FLAG_ONE:  return 1;
         FLAG_HALF: return depth / 2;
         default:   return depth;
      endcase
   endfunction

endpackage

// File: rtl/atf_stage.sv
// Pairs narrow writes into stereo entries; a wide write goes straight through.
module atf_stage #(
   parameter int SAMPLE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  half_we,
   input  logic                  word_we,
   input  logic [2*SAMPLE_W-1:0] data,
   output logic                  push,
   output logic [2*SAMPLE_W-1:0] push_data   // {right, left}
);

   logic                pending_q;
   logic [SAMPLE_W-1:0] held_left_q;

   always_comb begin
      push      = 1'b0;
      push_data = '0;
      if (word_we) begin
         push      = 1'b1;
         push_data = data;
      end else if (half_we && pending_q) begin
         push      = 1'b1;
         push_data = {data[SAMPLE_W-1:0], held_left_q};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q   <= 1'b0;
         held_left_q <= '0;
      end else if (word_we) begin
         pending_q   <= 1'b0;
      end else if (half_we) begin
         pending_q <= ~pending_q;
         if (!pending_q) held_left_q <= data[SAMPLE_W-1:0];
      end
   end

   // R4: a wide write always leaves no half pair open
   a_r4_word_drops_left: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |=> !pending_q);

   // R3: a narrow write that completes a pair produces exactly one push
   a_r3_pair_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (half_we && !word_we && pending_q) |-> push);

endmodule

// File: rtl/atf_store.sv
// Circular storage of stereo entries with an occupancy counter.
module atf_store #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1),
   localparam int EW = 2 * SAMPLE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] push_data,
   input  logic          pop,        // only asserted when level_q != 0
   output logic [EW-1:0] head,
   output logic [LW-1:0] level_q,
   output logic [LW-1:0] level_d
);

   localparam logic [LW-1:0] LV_FULL = LW'(DEPTH);

   logic [EW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic          accept;

   assign accept = push && ((level_q != LV_FULL) || pop);
   assign head   = mem_q[rd_ptr_q];

   always_comb begin
      level_d = level_q;
      if (accept && !pop)      level_d = level_q + LW'(1);
      else if (!accept && pop) level_d = level_q - LW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else begin
         level_q <= level_d;
         if (accept) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (pop)    rd_ptr_q <= rd_ptr_q + AW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                          mem_q[i] <= '0;
         else if (accept && wr_ptr_q == AW'(i)) mem_q[i] <= push_data;
      end
   end

   // R5: occupancy never exceeds the depth
   a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LV_FULL);

   // R5: a write against a full FIFO without a pop leaves it full
   a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level_q == LV_FULL) |=> level_q == LV_FULL);

endmodule

// File: rtl/atf_flags.sv
// Sticky free-space flags, one per threshold, set as the free count rises.
module atf_flags #(
   parameter int DEPTH = 4,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LW-1:0]              level_q,
   input  logic [LW-1:0]              level_d,
   input  logic [atf_pkg::NFLAGS-1:0] clr,
   output logic [atf_pkg::NFLAGS-1:0] flags
);

   for (genvar k = 0; k < atf_pkg::NFLAGS; k++) begin : g_flag
      localparam int            THR     = atf_pkg::flag_threshold(k, DEPTH);
      localparam logic [LW-1:0] LV_AT   = LW'(DEPTH - THR);
      localparam logic [LW-1:0] LV_PREV = LW'(DEPTH - THR + 1);

      logic hit;
      assign hit = (level_q == LV_PREV) && (level_d == LV_AT);

      always_ff @(posedge clk) begin
         if (!rst_n)      flags[k] <= 1'b0;
         else if (hit)    flags[k] <= 1'b1;
         else if (clr[k]) flags[k] <= 1'b0;
      end

      // R8 R9 R10: a flag rises only together with its threshold level
      a_r8_flag_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[k]) |-> level_q == LV_AT);

      // R11: without a clear pulse a set flag stays set
      a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && !clr[k]) |=> flags[k]);
   end

endmodule

// File: rtl/audio_tx_fifo_irq.sv
// Stereo audio transmit FIFO with shared free-space interrupt.
module audio_tx_fifo_irq #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 4,
   localparam int LW = $clog2(DEPTH + 1),
   localparam int EW = 2 * SAMPLE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run_en,
   input  logic                       wr_half,
   input  logic                       wr_word,
   input  logic [EW-1:0]              wr_data,
   input  logic [atf_pkg::NFLAGS-1:0] irq_en,
   input  logic [atf_pkg::NFLAGS:0]   status_clr,
   input  logic                       pop_req,
   output logic                       out_valid,
   output logic [SAMPLE_W-1:0]        out_left,
   output logic [SAMPLE_W-1:0]        out_right,
   output logic [LW-1:0]              level,
   output logic [atf_pkg::NFLAGS-1:0] flags,
   output logic                       underrun,
   output logic                       irq
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("audio_tx_fifo_irq: DEPTH must be a power of two, at least 4");
   end
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("audio_tx_fifo_irq: SAMPLE_W must be positive");
   end

   localparam logic [LW-1:0] LV_FULL = LW'(DEPTH);

   logic          push;
   logic [EW-1:0] push_data, head;
   logic [LW-1:0] level_q, level_d;
   logic          primed_q, pop_try, pop_fire;

   atf_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .half_we(wr_half), .word_we(wr_word),
      .data(wr_data), .push(push), .push_data(push_data));

   atf_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(pop_fire), .head(head), .level_q(level_q), .level_d(level_d));

   atf_flags #(.DEPTH(DEPTH)) u_flags (
      .clk(clk), .rst_n(rst_n), .level_q(level_q), .level_d(level_d),
      .clr(status_clr[atf_pkg::NFLAGS-1:0]), .flags(flags));

   assign pop_try  = pop_req && run_en;
   assign pop_fire = pop_try && primed_q && (level_q != '0);
   assign level    = level_q;
   assign irq      = |(flags & irq_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         primed_q  <= 1'b0;
         underrun  <= 1'b0;
         out_valid <= 1'b0;
         out_left  <= '0;
         out_right <= '0;
      end else begin
         primed_q  <= run_en && (primed_q || level_d == LV_FULL);
         underrun  <= (underrun && !status_clr[atf_pkg::CLR_UNDER]) ||
                      (pop_try && primed_q && level_q == '0);
         out_valid <= pop_try;
         out_left  <= pop_fire ? head[SAMPLE_W-1:0] : '0;
         out_right <= pop_fire ? head[EW-1:SAMPLE_W] : '0;
      end
   end

   // R6: occupancy only drops after the FIFO was armed
   a_r6_no_pop_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q < $past(level_q)) |-> $past(primed_q));

   // R13: underrun rises only after a request against an armed empty FIFO
   a_r13_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(pop_req && run_en && level_q == '0));

   // R13 R6: a refused request produces silence
   a_r13_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_try && !(primed_q && level_q != '0)) |=> (out_left == '0 && out_right == '0));

   // R14: no output pulse without run
   a_r14_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !out_valid);

endmodule

// File: tb/audio_tx_fifo_irq_test.sv
module audio_tx_fifo_irq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0, wr_half = 1'b0, wr_word = 1'b0, pop_req = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  irq_en = '0;
   logic [3:0]  status_clr = '0;
   logic        out_valid, underrun, irq;
   logic [15:0] out_left, out_right;
   logic [2:0]  level, flags;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // bench model
   logic [31:0] mq[$];     // {right,left}
   logic [31:0] exp_q[$];  // expected output samples
   bit          m_pend = 0, m_primed = 0, m_under = 0;
   logic [15:0] m_left = '0;
   logic [2:0]  m_flags = '0;

   always #4 clk = ~clk;   // 125 MHz

   audio_tx_fifo_irq uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_half(wr_half),
      .wr_word(wr_word), .wr_data(wr_data), .irq_en(irq_en),
      .status_clr(status_clr), .pop_req(pop_req), .out_valid(out_valid),
      .out_left(out_left), .out_right(out_right), .level(level),
      .flags(flags), .underrun(underrun), .irq(irq));

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      check(level == 3'(mq.size()), {req, " level"}, 32'(level), 32'(mq.size()));
      check(flags == m_flags, {req, " flags"}, 32'(flags), 32'(m_flags));
      check(underrun == m_under, {req, " underrun"}, 32'(underrun), 32'(m_under));
      check(irq == |(m_flags & irq_en), {req, " irq"}, 32'(irq), 32'(|(m_flags & irq_en)));
   endtask

   // monitor: compares each output pulse with the scoreboard (R7)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0)
            check(1'b0, "R7 unexpected out_valid", {out_right, out_left}, 32'h0);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check({out_right, out_left} == e, "R7 R2 R3 output sample",
                  {out_right, out_left}, e);
         end
      end
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic write_word(input logic [31:0] d);
      wr_word = 1'b1; wr_data = d;
      m_pend = 0;
      if (mq.size() < 4) mq.push_back(d);
      if (run_en && mq.size() == 4) m_primed = 1;
      cyc();
      wr_word = 1'b0;
   endtask

   task automatic write_half(input logic [15:0] d);
      wr_half = 1'b1; wr_data = {16'h0, d};
      if (!m_pend) begin
         m_left = d; m_pend = 1;
      end else begin
         m_pend = 0;
         if (mq.size() < 4) mq.push_back({d, m_left});
         if (run_en && mq.size() == 4) m_primed = 1;
      end
      cyc();
      wr_half = 1'b0;
   endtask

   task automatic pop_one();
      pop_req = 1'b1;
      if (run_en) begin
         if (m_primed && mq.size() > 0) begin
            int free_now;
            exp_q.push_back(mq.pop_front());
            free_now = 4 - mq.size();
            if (free_now == 1) m_flags[0] = 1'b1;
            if (free_now == 2) m_flags[1] = 1'b1;
            if (free_now == 4) m_flags[2] = 1'b1;
         end else begin
            exp_q.push_back(32'h0);
            if (m_primed) m_under = 1;
         end
      end
      cyc();
      pop_req = 1'b0;
   endtask

   task automatic clear(input logic [3:0] c);
      status_clr = c;
      m_flags = m_flags & ~c[2:0];
      if (c[3]) m_under = 0;
      cyc();
      status_clr = '0;
   endtask

   task automatic set_run(input bit r);
      run_en = r;
      if (!r) m_primed = 0;
      else if (mq.size() == 4) m_primed = 1;
      cyc();
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      check(out_valid == 0 && out_left == 0 && out_right == 0, "R1 outputs",
            {out_right, out_left}, 32'h0);
      check_state("R1");

      set_run(1);
      pop_one();                          // R6: not armed yet
      check_state("R6 pop before fill");

      write_word(32'h2222_1111);
      check_state("R2 wide write");
      write_half(16'h3333);
      check_state("R3 lone left");
      write_half(16'h4444);
      check_state("R3 pair commit");
      write_word(32'h6666_5555);
      write_word(32'h8888_7777);
      check_state("R5 full");
      write_word(32'hAAAA_9999);
      check_state("R5 dropped write");

      pop_one();
      check_state("R8 R12 one free masked");
      irq_en = 3'b001; cyc();
      check_state("R12 enable");
      pop_one();
      check_state("R9 half free");
      clear(4'b0001);
      check_state("R11 clear one");
      pop_one();
      check_state("R11 sticky");
      pop_one();
      check_state("R10 all free");
      irq_en = 3'b100; cyc();
      check_state("R12 all free irq");

      pop_one();
      check_state("R13 underrun");
      clear(4'b1000);
      check_state("R13 underrun clear");
      clear(4'b0111);
      check_state("R11 clear all");

      write_half(16'hBBBB);
      write_word(32'hDDDD_CCCC);
      check_state("R4 wide after half");
      write_half(16'hEEEE);
      check_state("R4 new left");
      write_half(16'hFFFF);
      check_state("R4 new pair");

      set_run(0);
      pop_req = 1'b1; cyc(); pop_req = 1'b0;   // R14
      check(out_valid == 0, "R14 no valid", 32'(out_valid), 32'h0);
      check_state("R14 ignored pop");

      set_run(1);
      pop_one();
      check_state("R6 re-armed");
      write_word(32'h1234_5678);
      write_word(32'h9ABC_DEF0);
      check_state("R6 filled");
      for (int i = 0; i < 4; i++) begin
         pop_one();
         check_state("R7 drain");
      end
      cyc(); cyc();
      check(exp_q.size() == 0, "R7 all outputs seen", 32'(exp_q.size()), 32'h0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule